// File: doc/BRIEF.md
# Banked Interrupt Control Unit

This block gathers level-sensitive interrupt requests from on-chip peripherals into a small number of processor request lines. Requests are grouped in banks of 32 lines, five banks by default. Every bank latches incoming requests in a sticky pending register. An enable register masks that pending register. The masked result drives the bank's processor request line. Software reaches all registers over a simple register bus. Each bank's window starts at a fixed byte stride of 0x28.

For fast dispatch, each bank also presents a registered index of its highest-numbered pending-and-enabled line, together with a valid flag. The interrupt handler services that line first. It then acknowledges the line by writing a one to the matching pending bit. Lower-numbered bits of the masked view are treated as advisory only. Dispatch always goes by the most significant set bit.

Top module: `icu_banked`

## Requirements
- R1: Bank n occupies bus byte addresses n*0x28 to n*0x28+0x27. Within a bank the word offsets are: pending 0x00, enable 0x08, masked view 0x10, line levels 0x18, mode 0x20. Read data appears on `bus_rdata` one clock after the address is presented.
- R2: A pending bit becomes 1 on the clock edge at which its request line is high. It then stays 1 after the line drops, until software clears it.
- R3: Writing the pending register clears every bit written as 1. Bits written as 0 keep their value.
- R4: A clear takes effect even if the line is high during the write cycle. A line that is still high sets the bit again on the following edge.
- R5: The masked view reads as pending AND enable. Pending bits whose enable bit is 0 raise no request.
- R6: `cpu_irq[n]` is high exactly when bank n's masked view is nonzero. It follows register changes in the same cycle.
- R7: `disp_idx` for bank n gives the position of the highest set bit of the masked view, and `disp_valid[n]` flags it as nonzero. Both reflect the masked view one clock later.
- R8: The line-level register returns the live request inputs of the bank. Writes to the line-level register and to the masked view are ignored.
- R9: The mode register is a 32-bit read/write word per bank. Its contents do not change request routing.
- R10: Offsets within a bank other than the five listed, and addresses at or above NUM_BANKS*0x28, read as zero and ignore writes.
- R11: After reset, pending, enable and mode are zero, and no request or dispatch flag is raised. Writing zero to every enable register and all-ones to every pending register also leaves no request raised.
- R12: Request input `irq_lines[m*32+k]` feeds bit k of bank m.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_lines | input | NUM_BANKS*LINES | Level request inputs, bank-major |
| bus_addr | input | ADDR_W | Byte address for read and write |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | LINES | Write data |
| bus_rdata | output | LINES | Registered read data |
| cpu_irq | output | NUM_BANKS | Per-bank processor request |
| disp_idx | output | NUM_BANKS*IDX_W | Per-bank index of highest masked pending bit |
| disp_valid | output | NUM_BANKS | Per-bank flag that the index is meaningful |

## Verification
The hardest case to reach from the ports is the race between an acknowledge and a request line that is still asserted. The clear must win for exactly one cycle, and the bit must then come back. The bench holds a line high, issues the write-one-to-clear in that same window, and samples `cpu_irq` on the two consecutive cycles. The second subtle case is the one-cycle lag of the dispatch flag behind the request line after a full clear. The bench observes it right after the clearing write.

// File: rtl/icu_pkg.sv
package icu_pkg;

  localparam int unsigned OFS_PENDING = 32'h00;
  localparam int unsigned OFS_ENABLE  = 32'h08;
  localparam int unsigned OFS_MASKED  = 32'h10;
  localparam int unsigned OFS_LEVEL   = 32'h18;
  localparam int unsigned OFS_MODE    = 32'h20;

  typedef enum logic [2:0] {
    REG_NONE,
    REG_PENDING,
    REG_ENABLE,
    REG_MASKED,
    REG_LEVEL,
    REG_MODE
  } reg_kind_e;

  function automatic reg_kind_e decode_ofs(input int unsigned ofs);
    case (ofs)
      OFS_PENDING: return REG_PENDING;
      OFS_ENABLE:  return REG_ENABLE;
      OFS_MASKED:  return REG_MASKED;
      OFS_LEVEL:   return REG_LEVEL;
      OFS_MODE:    return REG_MODE;
      default:     return REG_NONE;
    endcase
  endfunction

endpackage

// File: rtl/icu_msb_find.sv
module icu_msb_find #(
  parameter int W    = 32,
  parameter int IW   = $clog2(W)
) (
  input  logic [W-1:0]  vec,
  output logic [IW-1:0] idx,
  output logic          found
);
  always_comb begin
    idx   = '0;
    found = |vec;
    for (int i = 0; i < W; i++) begin
      if (vec[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/icu_bank.sv
module icu_bank
  import icu_pkg::*;
#(
  parameter int LINES = 32,
  parameter int OFS_W = 6,
  parameter int IDX_W = $clog2(LINES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LINES-1:0] req_lines,
  input  logic             wr_en,
  input  logic [OFS_W-1:0] ofs,
  input  logic [LINES-1:0] wdata,
  output logic [LINES-1:0] rd_word,
  output logic             irq,
  output logic [IDX_W-1:0] top_idx,
  output logic             top_vld
);
  reg_kind_e        kind;
  logic [LINES-1:0] pend_q, en_q, mode_q, masked, clr_mask;
  logic [IDX_W-1:0] find_idx;
  logic             find_hit;
  logic             clr_wr;

  assign kind     = decode_ofs(32'(ofs));
  assign clr_wr   = wr_en && (kind == REG_PENDING);
  assign clr_mask = clr_wr ? wdata : '0;
  assign masked   = pend_q & en_q;
  assign irq      = |masked;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= '0;
      en_q   <= '0;
      mode_q <= '0;
    end else begin
      pend_q <= (pend_q | req_lines) & ~clr_mask;
      if (wr_en && kind == REG_ENABLE) en_q   <= wdata;
      if (wr_en && kind == REG_MODE)   mode_q <= wdata;
    end
  end

  icu_msb_find #(.W(LINES), .IW(IDX_W)) u_find (
    .vec  (masked),
    .idx  (find_idx),
    .found(find_hit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      top_idx <= '0;
      top_vld <= 1'b0;
    end else begin
      top_idx <= find_idx;
      top_vld <= find_hit;
    end
  end

  always_comb begin
    case (kind)
      REG_PENDING: rd_word = pend_q;
      REG_ENABLE:  rd_word = en_q;
      REG_MASKED:  rd_word = masked;
      REG_LEVEL:   rd_word = req_lines;
      REG_MODE:    rd_word = mode_q;
      default:     rd_word = '0;
    endcase
  end

  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (rst)
    clr_wr |=> ((pend_q & $past(wdata)) == '0)); // R4

  AST_STICKY_PENDING: assert property (@(posedge clk) disable iff (rst)
    !clr_wr |=> ((pend_q & $past(pend_q)) == $past(pend_q))); // R2

  AST_DISPATCH_TOP: assert property (@(posedge clk) disable iff (rst)
    top_vld |-> (($past(masked) >> top_idx) == LINES'(1))); // R7

endmodule

// File: rtl/icu_banked.sv
module icu_banked #(
  parameter int NUM_BANKS = 5,
  parameter int LINES     = 32,
  parameter int STRIDE    = 40,
  parameter int ADDR_W    = 8,
  parameter int IDX_W     = $clog2(LINES)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [NUM_BANKS*LINES-1:0] irq_lines,
  input  logic [ADDR_W-1:0]          bus_addr,
  input  logic                       bus_wr,
  input  logic [LINES-1:0]           bus_wdata,
  output logic [LINES-1:0]           bus_rdata,
  output logic [NUM_BANKS-1:0]       cpu_irq,
  output logic [NUM_BANKS*IDX_W-1:0] disp_idx,
  output logic [NUM_BANKS-1:0]       disp_valid
);
  localparam int OFS_W = $clog2(STRIDE);

  logic [NUM_BANKS-1:0] bank_hit;
  logic [LINES-1:0]     bank_rd [NUM_BANKS];
  logic [LINES-1:0]     rd_mux;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    localparam int unsigned BASE = b * STRIDE;
    logic [OFS_W-1:0] ofs_b;

    assign bank_hit[b] = (32'(bus_addr) >= BASE) && (32'(bus_addr) < BASE + STRIDE);
    assign ofs_b       = OFS_W'(32'(bus_addr) - BASE);

    icu_bank #(.LINES(LINES), .OFS_W(OFS_W), .IDX_W(IDX_W)) u_bank (
      .clk      (clk),
      .rst      (rst),
      .req_lines(irq_lines[b*LINES +: LINES]),
      .wr_en    (bus_wr && bank_hit[b]),
      .ofs      (ofs_b),
      .wdata    (bus_wdata),
      .rd_word  (bank_rd[b]),
      .irq      (cpu_irq[b]),
      .top_idx  (disp_idx[b*IDX_W +: IDX_W]),
      .top_vld  (disp_valid[b])
    );
  end

  always_comb begin
    rd_mux = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (bank_hit[b]) rd_mux = rd_mux | bank_rd[b];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= rd_mux;
  end

  AST_UNMAPPED_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
    (bank_hit == '0) |=> (bus_rdata == '0)); // R10

endmodule

// File: tb/tb_icu_banked.sv
module tb_icu_banked;
  localparam int NB = 5;
  localparam int NL = 32;
  localparam int IW = 5;

  logic              clk = 1'b0;
  logic              rst;
  logic [NB*NL-1:0]  irq_lines;
  logic [7:0]        bus_addr;
  logic              bus_wr;
  logic [NL-1:0]     bus_wdata;
  logic [NL-1:0]     bus_rdata;
  logic [NB-1:0]     cpu_irq;
  logic [NB*IW-1:0]  disp_idx;
  logic [NB-1:0]     disp_valid;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  icu_banked dut (
    .clk(clk), .rst(rst), .irq_lines(irq_lines), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cpu_irq(cpu_irq), .disp_idx(disp_idx), .disp_valid(disp_valid)
  );

  // {write, addr, data, expected read}
  localparam logic [72:0] VEC_TAB [0:10] = '{
    {1'b1, 8'h30, 32'h0000_F00F, 32'h0},           // R1 enable bank1
    {1'b0, 8'h30, 32'h0,         32'h0000_F00F},   // R1 enable readback
    {1'b1, 8'h48, 32'hA5A5_0001, 32'h0},           // R9 mode write
    {1'b0, 8'h48, 32'h0,         32'hA5A5_0001},   // R9 mode readback
    {1'b0, 8'h28, 32'h0,         32'h0},           // R11 pending after reset
    {1'b1, 8'h38, 32'hFFFF_FFFF, 32'h0},           // R8 write to masked view
    {1'b0, 8'h38, 32'h0,         32'h0},           // R8 masked view unchanged
    {1'b0, 8'h2C, 32'h0,         32'h0},           // R10 unused offset
    {1'b1, 8'h2C, 32'hFFFF_FFFF, 32'h0},           // R10 write unused offset
    {1'b0, 8'h2C, 32'h0,         32'h0},           // R10 still zero
    {1'b0, 8'hC8, 32'h0,         32'h0}            // R10 beyond last bank
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_write(input logic [7:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic do_read(input logic [7:0] a, output logic [31:0] v);
    bus_addr = a; bus_wr = 1'b0;
    @(negedge clk);
    v = bus_rdata;
  endtask

  task automatic pulse_line(input int n);
    irq_lines[n] = 1'b1;
    @(negedge clk);
    irq_lines[n] = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    rst = 1'b1; irq_lines = '0; bus_addr = '0; bus_wr = 1'b0; bus_wdata = '0;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    check("R11 irq after reset", 32'(cpu_irq), 32'h0);
    check("R11 valid after reset", 32'(disp_valid), 32'h0);

    for (int i = 0; i < 11; i++) begin
      if (VEC_TAB[i][72]) do_write(VEC_TAB[i][71:64], VEC_TAB[i][63:32]);
      else begin
        do_read(VEC_TAB[i][71:64], v);
        check($sformatf("table %0d addr %h", i, VEC_TAB[i][71:64]), v, VEC_TAB[i][31:0]);
      end
    end

    pulse_line(35);
    check("R6 bank1 irq", 32'(cpu_irq), 32'h2);
    do_read(8'h28, v);
    check("R2 sticky pending", v, 32'h8);
    check("R7 valid bank1", 32'(disp_valid), 32'h2);
    check("R7 index bank1", 32'(disp_idx[9:5]), 32'd3);

    irq_lines[40] = 1'b1;
    do_read(8'h40, v);
    check("R8 line levels", v, 32'h100);
    irq_lines[40] = 1'b0;
    do_read(8'h38, v);
    check("R5 masked view", v, 32'h8);
    do_read(8'h28, v);
    check("R5 pending incl. disabled bit", v, 32'h108);

    pulse_line(46);
    @(negedge clk);
    check("R7 highest bit wins", 32'(disp_idx[9:5]), 32'd14);

    do_write(8'h28, 32'h0);
    do_read(8'h28, v);
    check("R3 zero write keeps bits", v, 32'h4108);
    do_write(8'h28, 32'h4000);
    do_read(8'h28, v);
    check("R3 one write clears bit", v, 32'h108);
    check("R7 index after clear", 32'(disp_idx[9:5]), 32'd3);

    irq_lines[35] = 1'b1;
    do_write(8'h28, 32'h8);
    check("R4 clear wins", 32'(cpu_irq[1]), 32'h0);
    @(negedge clk);
    check("R4 line re-sets", 32'(cpu_irq[1]), 32'h1);
    irq_lines[35] = 1'b0;

    do_write(8'h28, 32'hFFFF_FFFF);
    check("R6 irq drops at once", 32'(cpu_irq[1]), 32'h0);
    check("R7 valid lags one cycle", 32'(disp_valid[1]), 32'h1);
    @(negedge clk);
    check("R7 valid cleared", 32'(disp_valid[1]), 32'h0);

    do_write(8'hA8, 32'h8000_0000);
    pulse_line(159);
    check("R12 last bank only", 32'(cpu_irq), 32'h10);
    @(negedge clk);
    check("R12 last bank index", 32'(disp_idx[24:20]), 32'd31);

    pulse_line(0);
    check("R5 disabled bank0 quiet", 32'(cpu_irq[0]), 32'h0);
    do_read(8'h00, v);
    check("R12 bank0 bit0", v, 32'h1);

    for (int b = 0; b < NB; b++) begin
      do_write(8'(b*40 + 8), 32'h0);
      do_write(8'(b*40), 32'hFFFF_FFFF);
    end
    check("R11 quiesced irq", 32'(cpu_irq), 32'h0);
    @(negedge clk);
    check("R11 quiesced valid", 32'(disp_valid), 32'h0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule